// File: doc/BRIEF.md
# Input-Activity Idle Power-Down Detector

This block watches a wide bundle of logic inputs and raises a power-down indication once none of them has moved for a fixed number of clock cycles. The idle interval stands for roughly 70 ns of wall-clock time. It is a cycle count parameter: the default of 7 cycles assumes a 100 MHz clock. As soon as any watched input differs from the value it had at the previous clock edge, the indication drops in that same cycle and the idle count starts again.

A turbo configuration bit turns the feature off. While turbo is set, the indication is held low and the count is held at zero. The block also produces two registered clock enables, one for the logic array and one for the macrocells. Each enable is driven by its own disable bit.

Top module: `idle_pwrdn`

## Requirements
- R1: While rst_ni is low, pwrdn_o is 0 and both clock enables (arr_clk_en_o, mc_clk_en_o) are 1.
- R2: With turbo_i low, pwrdn_o goes to 1 once bus_i has been equal to the value sampled at the previous edge on IDLE_CYCLES consecutive clock edges.
- R3: When bus_i differs from the value sampled at the last clock edge, pwrdn_o is 0 in that same cycle without waiting for an edge. After such a change, a full IDLE_CYCLES of unchanged edges is needed again.
- R4: While turbo_i is 1, pwrdn_o is 0 in that same cycle. After turbo_i returns to 0, IDLE_CYCLES unchanged edges are needed before pwrdn_o rises.
- R5: The first clock edge after reset only captures bus_i and is not counted as idle. pwrdn_o therefore first rises at edge IDLE_CYCLES+1 after reset release.
- R6: arr_clk_en_o equals the inverse of arr_clk_dis_i as sampled at the previous clock edge.
- R7: mc_clk_en_o equals the inverse of mc_clk_dis_i as sampled at the previous clock edge, independently of the array control.
- R8: A change on any single bit of bus_i counts as activity, including bit 0 and the top bit BUS_W-1.
- R9: pwrdn_o stays at 1 for as long as bus_i is unchanged and turbo_i is low, however long that lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | BUS_W | Watched input bundle |
| turbo_i | input | 1 | 1 disables automatic power-down |
| arr_clk_dis_i | input | 1 | 1 gates off the logic array clock |
| mc_clk_dis_i | input | 1 | 1 gates off the macrocell clock |
| pwrdn_o | output | 1 | Power-down indication |
| arr_clk_en_o | output | 1 | Registered logic array clock enable |
| mc_clk_en_o | output | 1 | Registered macrocell clock enable |

## Verification
The bench builds the block with BUS_W=61, IDLE_CYCLES=4 and LANE_W=16. With these values the change detector has four lanes, and the last lane is only 13 bits wide, so a toggle on the top bit exercises the partial-lane slice. The short interval lets the bench reach the exact rise edge, saturation and re-arming after a change or after turbo many times within a few hundred cycles. Sparse random activity, combined with random turbo and disable toggling, is compared every cycle against a behavioural model.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  typedef enum int {
    DOM_ARRAY = 0,
    DOM_MCELL = 1
  } clk_dom_e;
  localparam int NUM_DOMAINS = 2;
endpackage

// File: rtl/ipd_change_det.sv
module ipd_change_det #(
  parameter int BUS_W  = 61,
  parameter int LANE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  output logic             armed_o,
  output logic             change_o
);
  localparam int NUM_LANES = (BUS_W + LANE_W - 1) / LANE_W;

  logic [BUS_W-1:0]     prev_q;
  logic                 armed_q;
  logic [NUM_LANES-1:0] lane_hit;

  // Snapshot of the bus; armed_q marks that it holds a real sample.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= bus_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    localparam int HI = ((i + 1) * LANE_W > BUS_W) ? BUS_W - 1 : (i + 1) * LANE_W - 1;
    assign lane_hit[i] = |(bus_i[HI:LO] ^ prev_q[HI:LO]);
  end

  assign armed_o  = armed_q;
  assign change_o = armed_q & (|lane_hit);
endmodule

// File: rtl/ipd_idle_timer.sv
module ipd_idle_timer #(
  parameter int IDLE_CYCLES = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic change_i,
  input  logic turbo_i,
  output logic pwrdn_o
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             at_max;

  assign restart = turbo_i | change_i | ~armed_i;
  assign at_max  = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!at_max) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Combinational release: activity or turbo drops the flag without an edge.
  assign pwrdn_o = at_max & ~change_i & ~turbo_i;
endmodule

// File: rtl/ipd_clk_en.sv
module ipd_clk_en
  import ipd_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_DOMAINS-1:0] dis_i,
  output logic [NUM_DOMAINS-1:0] en_o
);
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= ~dis_i[d];
    end
    assign en_o[d] = en_q;
  end
endmodule

// File: rtl/idle_pwrdn.sv
module idle_pwrdn
  import ipd_pkg::*;
#(
  parameter int BUS_W       = 61,
  parameter int IDLE_CYCLES = 7,
  parameter int LANE_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             turbo_i,
  input  logic             arr_clk_dis_i,
  input  logic             mc_clk_dis_i,
  output logic             pwrdn_o,
  output logic             arr_clk_en_o,
  output logic             mc_clk_en_o
);
  logic                   armed;
  logic                   change;
  logic [NUM_DOMAINS-1:0] dom_dis;
  logic [NUM_DOMAINS-1:0] dom_en;

  ipd_change_det #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    (bus_i),
    .armed_o  (armed),
    .change_o (change)
  );

  ipd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (armed),
    .change_i (change),
    .turbo_i  (turbo_i),
    .pwrdn_o  (pwrdn_o)
  );

  assign dom_dis[DOM_ARRAY] = arr_clk_dis_i;
  assign dom_dis[DOM_MCELL] = mc_clk_dis_i;

  ipd_clk_en u_cen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dis_i  (dom_dis),
    .en_o   (dom_en)
  );

  assign arr_clk_en_o = dom_en[DOM_ARRAY];
  assign mc_clk_en_o  = dom_en[DOM_MCELL];
endmodule

// File: rtl/idle_pwrdn_chk.sv
module idle_pwrdn_chk #(
  parameter int BUS_W       = 61,
  parameter int IDLE_CYCLES = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] bus_i,
  input logic             turbo_i,
  input logic             arr_clk_dis_i,
  input logic             mc_clk_dis_i,
  input logic             pwrdn_o,
  input logic             arr_clk_en_o,
  input logic             mc_clk_en_o
);
  int               quiet_cnt;
  logic [BUS_W-1:0] seen_q;
  logic             seen_ok;

  // Consecutive edges with an unchanged bus and turbo low.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_cnt <= 0;
      seen_q    <= '0;
      seen_ok   <= 1'b0;
    end else begin
      seen_q  <= bus_i;
      seen_ok <= 1'b1;
      if (!seen_ok || turbo_i || bus_i != seen_q) quiet_cnt <= 0;
      else if (quiet_cnt < IDLE_CYCLES)           quiet_cnt <= quiet_cnt + 1;
    end
  end

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!pwrdn_o);
  end

  assert_rise_needs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_o |-> quiet_cnt >= IDLE_CYCLES);

  assert_activity_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_ok && bus_i != seen_q) |-> !pwrdn_o);

  assert_turbo_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turbo_i |-> !pwrdn_o);

  assert_arr_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> arr_clk_en_o == !$past(arr_clk_dis_i));

  assert_mc_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mc_clk_en_o == !$past(mc_clk_dis_i));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt >= IDLE_CYCLES && !turbo_i && seen_ok && bus_i == seen_q) |-> pwrdn_o);
endmodule

bind idle_pwrdn idle_pwrdn_chk #(.BUS_W(BUS_W), .IDLE_CYCLES(IDLE_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_i         (bus_i),
  .turbo_i       (turbo_i),
  .arr_clk_dis_i (arr_clk_dis_i),
  .mc_clk_dis_i  (mc_clk_dis_i),
  .pwrdn_o       (pwrdn_o),
  .arr_clk_en_o  (arr_clk_en_o),
  .mc_clk_en_o   (mc_clk_en_o)
);

// File: tb/idle_pwrdn_test.sv
module idle_pwrdn_test;
  localparam int BW = 61;
  localparam int IC = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] bus = '0;
  logic          turbo = 1'b0;
  logic          adis = 1'b0;
  logic          mdis = 1'b0;
  logic          pwrdn, aen, men;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idle_pwrdn #(.BUS_W(BW), .IDLE_CYCLES(IC), .LANE_W(LW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .bus_i (bus), .turbo_i (turbo),
    .arr_clk_dis_i (adis), .mc_clk_dis_i (mdis),
    .pwrdn_o (pwrdn), .arr_clk_en_o (aen), .mc_clk_en_o (men)
  );

  // Behavioural reference
  int            m_idle;
  bit            m_armed;
  logic [BW-1:0] m_prev;
  logic          m_aen, m_men;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle = 0; m_armed = 0; m_prev = '0; m_aen = 1; m_men = 1;
    end else begin
      if (!m_armed || turbo || bus != m_prev) m_idle = 0;
      else if (m_idle < IC) m_idle = m_idle + 1;
      m_armed = 1; m_prev = bus; m_aen = !adis; m_men = !mdis;
    end
  end

  function automatic logic exp_pd();
    return rst_n && (m_idle == IC) && !turbo && !(m_armed && bus != m_prev);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2 R3 R4 pwrdn_o", pwrdn, exp_pd());
      check("R6 arr_clk_en_o", aen, m_aen);
      check("R7 mc_clk_en_o", men, m_men);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bus = {4'h5, 57'h0_1234_5678_9abc};
    edges(2);
    check("R1 pwrdn in reset", pwrdn, 1'b0);
    check("R1 arr en in reset", aen, 1'b1);
    check("R1 mc en in reset", men, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    edges(IC);
    check("R5 not yet at edge IC", pwrdn, 1'b0);
    edges(1);
    check("R5 R2 rise at edge IC+1", pwrdn, 1'b1);
    edges(20);
    check("R9 stays asserted", pwrdn, 1'b1);

    @(negedge clk); bus[0] = ~bus[0]; #1;
    check("R8 R3 bit0 drops at once", pwrdn, 1'b0);
    edges(IC);
    check("R3 rearm not early", pwrdn, 1'b0);
    edges(1);
    check("R3 rearm after full idle", pwrdn, 1'b1);

    @(negedge clk); bus[BW-1] = ~bus[BW-1]; #1;
    check("R8 top bit drops at once", pwrdn, 1'b0);
    edges(IC + 1);
    check("R8 rearm after top bit", pwrdn, 1'b1);

    @(negedge clk); bus[20] = ~bus[20];
    edges(IC - 1);
    bus[33] = ~bus[33]; #1;
    check("R3 change just before threshold", pwrdn, 1'b0);
    edges(IC);
    check("R3 counter restarted", pwrdn, 1'b0);
    edges(1);
    check("R3 asserts after restart", pwrdn, 1'b1);

    @(negedge clk); turbo = 1'b1; #1;
    check("R4 turbo drops at once", pwrdn, 1'b0);
    edges(10);
    check("R4 turbo holds low", pwrdn, 1'b0);
    turbo = 1'b0;
    edges(IC - 1);
    check("R4 not early after turbo", pwrdn, 1'b0);
    edges(1);
    check("R4 asserts after turbo", pwrdn, 1'b1);

    @(negedge clk); adis = 1'b1; #1;
    check("R6 enable registered", aen, 1'b1);
    edges(1);
    check("R6 array gated", aen, 1'b0);
    check("R7 mc unaffected", men, 1'b1);
    mdis = 1'b1; adis = 1'b0;
    edges(1);
    check("R7 mc gated", men, 1'b0);
    check("R6 array back on", aen, 1'b1);
    check("R9 pwrdn unaffected by enables", pwrdn, 1'b1);
    mdis = 1'b0;

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) bus[$urandom_range(0, BW - 1)] ^= 1'b1;
      if ($urandom_range(0, 29) == 0) turbo = ~turbo;
      if ($urandom_range(0, 19) == 0) adis = ~adis;
      if ($urandom_range(0, 19) == 0) mdis = ~mdis;
    end
    edges(2);
    finish_run();
  end
endmodule